// File: doc/BRIEF.md
# Shift and Rotate Unit with Condition Flags

This block moves the bits of an 8-bit or 16-bit operand left or right. It supports plain shifts, arithmetic shifts, rotates, and rotates that pass through a carry bit. The distance is either a single position or an amount taken from a count value. A request is accepted on a clock edge while `go` is high. The shifted result and five condition flags (carry, overflow, sign, zero, parity) are registered and held until the next request.

The flags keep their state across requests. A request with a zero amount therefore leaves every flag as it was. A request with an amount above one keeps the previous overflow flag.

Top module: `srf_unit`

## Requirements
- R1: After reset `result` is 0 and `cf`, `of`, `sf`, `zf`, `pf` are all 0.
- R2: Opcodes 0 and 1 both shift left, filling bit 0 with zero. In byte mode FFh shifted left once gives FEh, and 0Bh shifted left by 2 gives 2Ch.
- R3: Opcode 2 shifts right, filling the top bit with zero. Opcode 3 shifts right, copying the top bit. In byte mode FFh gives 7Fh under opcode 2 and FFh under opcode 3. 0Bh shifted right by 2 gives 02h.
- R4: Opcode 4 rotates left and opcode 5 rotates right. The wrap point is bit 7 in byte mode and bit 15 in word mode. In byte mode 0Bh rotated left once gives 16h, and rotated right once gives 85h.
- R5: Opcode 6 rotates left and opcode 7 rotates right through `carry_in`. The carry acts as one extra bit above the operand's top bit, making a 9-bit ring in byte mode and a 17-bit ring in word mode.
- R6: The amount is 1 when `by_count` is 0. Otherwise it is the low 5 bits of `count_reg`, so a count of 21h acts as 1.
- R7: For a nonzero amount, `cf` becomes the last bit that left the operand. For the through-carry rotates this is the carry bit of the ring.
- R8: For an amount of exactly 1, `of` becomes 1 when the result's top bit differs from the operand's top bit, and 0 otherwise. For amounts of 2 or more, `of` keeps its value.
- R9: For a nonzero amount, `sf` is the top bit of the result for the selected size. `zf` is 1 when that result is zero. `pf` is 1 when the low 8 result bits hold an even number of ones.
- R10: A zero amount loads `result` with the operand, limited to the selected size, and leaves all five flags unchanged.
- R11: In byte mode (`word_mode` = 0) only operand bits 7..0 take part, and result bits 15..8 are 0.
- R12: Outputs change only on the clock edge where `go` is high, one cycle after the request. They hold while `go` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| go | input | 1 | Accept a request on this edge |
| opcode | input | 3 | Operation select (see R2 to R5) |
| word_mode | input | 1 | 1 = 16-bit operand, 0 = 8-bit operand |
| by_count | input | 1 | 1 = amount from count_reg, 0 = amount of 1 |
| count_reg | input | 8 | Count value; low 5 bits used |
| operand | input | 16 | Data to shift or rotate |
| carry_in | input | 1 | Carry entering the through-carry rotates |
| result | output | 16 | Registered result |
| cf | output | 1 | Carry flag |
| of | output | 1 | Overflow flag |
| sf | output | 1 | Sign flag |
| zf | output | 1 | Zero flag |
| pf | output | 1 | Parity flag |

## Verification
Two cases are hard to reach from the ports.

The first is flag retention. It only shows when a request that sets a flag is followed by one that must leave it alone: a zero amount, or an amount above one for overflow. Random traffic rarely produces such pairs with the flag actually set, so the stimulus biases the count toward 0, 1 and values whose low five bits are zero (20h, 40h).

The second is long through-carry rotates that wrap the whole 9-bit or 17-bit ring. Directed cases place a one-bit-set operand in the ring to cover these.

// File: rtl/srf_pkg.sv
package srf_pkg;

  typedef enum logic [2:0] {
    SRF_SHL = 3'd0,
    SRF_SAL = 3'd1,
    SRF_SHR = 3'd2,
    SRF_SAR = 3'd3,
    SRF_ROL = 3'd4,
    SRF_ROR = 3'd5,
    SRF_RCL = 3'd6,
    SRF_RCR = 3'd7
  } srf_op_e;

  typedef struct packed {
    logic cf;
    logic of;
    logic sf;
    logic zf;
    logic pf;
  } srf_flags_t;

endpackage

// File: rtl/srf_amount.sv
module srf_amount #(
  parameter int CNT_W = 8,
  parameter int AMT_W = 5
) (
  input  logic             by_count,
  input  logic [CNT_W-1:0] count_reg,
  output logic [AMT_W-1:0] amt,
  output logic             amt_zero,
  output logic             amt_one
);
  // R6: single position unless the count value is selected; count masked
  assign amt      = by_count ? count_reg[AMT_W-1:0] : AMT_W'(1);
  assign amt_zero = (amt == '0);
  assign amt_one  = (amt == AMT_W'(1));
endmodule

// File: rtl/srf_core.sv
module srf_core
  import srf_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int AMT_W  = 5
) (
  input  srf_op_e           op,
  input  logic              word_mode,
  input  logic [DATA_W-1:0] operand,
  input  logic              carry_in,
  input  logic [AMT_W-1:0]  amt,
  output logic [DATA_W-1:0] res,
  output logic              cy
);
  localparam int HALF_W  = DATA_W / 2;
  localparam int MAX_AMT = (1 << AMT_W) - 1;
  localparam int IDX_W   = $clog2(DATA_W);

  function automatic logic [DATA_W-1:0] size_mask(input logic wm);
    return wm ? {DATA_W{1'b1}} : DATA_W'({HALF_W{1'b1}});
  endfunction

  // one position of any operation; returns {carry, data}
  function automatic logic [DATA_W:0] step(input srf_op_e o, input logic wm,
                                           input logic [DATA_W-1:0] d, input logic c);
    logic [IDX_W-1:0]  top;
    logic [DATA_W-1:0] nd;
    logic              nc;
    top = wm ? IDX_W'(DATA_W-1) : IDX_W'(HALF_W-1);
    nd  = d;
    nc  = c;
    case (o)
      SRF_SHL, SRF_SAL: begin nc = d[top]; nd = d << 1; end
      SRF_SHR:          begin nc = d[0];   nd = d >> 1; end
      SRF_SAR:          begin nc = d[0];   nd = d >> 1; nd[top] = d[top]; end
      SRF_ROL:          begin nc = d[top]; nd = d << 1; nd[0]   = d[top]; end
      SRF_ROR:          begin nc = d[0];   nd = d >> 1; nd[top] = d[0];   end
      SRF_RCL:          begin nc = d[top]; nd = d << 1; nd[0]   = c;      end
      SRF_RCR:          begin nc = d[0];   nd = d >> 1; nd[top] = c;      end
      default:          begin nc = c;      nd = d; end
    endcase
    return {nc, nd & size_mask(wm)};
  endfunction

  logic [DATA_W:0] chain [0:MAX_AMT];

  assign chain[0] = {carry_in, operand & size_mask(word_mode)};

  for (genvar gi = 0; gi < MAX_AMT; gi++) begin : g_stage
    assign chain[gi+1] = (AMT_W'(gi) < amt)
                       ? step(op, word_mode, chain[gi][DATA_W-1:0], chain[gi][DATA_W])
                       : chain[gi];
  end

  assign res = chain[MAX_AMT][DATA_W-1:0];
  assign cy  = chain[MAX_AMT][DATA_W];
endmodule

// File: rtl/srf_flags.sv
module srf_flags #(
  parameter int DATA_W = 16
) (
  input  logic              word_mode,
  input  logic [DATA_W-1:0] src,
  input  logic [DATA_W-1:0] res,
  output logic              sign_v,
  output logic              zero_v,
  output logic              par_v,
  output logic              sign_flip
);
  localparam int HALF_W = DATA_W / 2;

  function automatic logic top_bit(input logic wm, input logic [DATA_W-1:0] v);
    return wm ? v[DATA_W-1] : v[HALF_W-1];
  endfunction

  function automatic logic even_ones(input logic [7:0] v);
    return ~(^v);
  endfunction

  assign sign_v    = top_bit(word_mode, res);
  assign zero_v    = (res == '0);
  assign par_v     = even_ones(res[7:0]);
  assign sign_flip = top_bit(word_mode, res) ^ top_bit(word_mode, src);
endmodule

// File: rtl/srf_unit.sv
module srf_unit
  import srf_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 8,
  parameter int AMT_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [2:0]        opcode,
  input  logic              word_mode,
  input  logic              by_count,
  input  logic [CNT_W-1:0]  count_reg,
  input  logic [DATA_W-1:0] operand,
  input  logic              carry_in,
  output logic [DATA_W-1:0] result,
  output logic              cf,
  output logic              of,
  output logic              sf,
  output logic              zf,
  output logic              pf
);
  localparam int HALF_W = DATA_W / 2;

  logic [AMT_W-1:0]  amt;
  logic              amt_zero, amt_one;
  logic [DATA_W-1:0] core_res, src_masked;
  logic              core_cy;
  logic              sign_v, zero_v, par_v, sign_flip;
  srf_flags_t        flg_q;

  assign src_masked = word_mode ? operand : DATA_W'(operand[HALF_W-1:0]);

  srf_amount #(.CNT_W(CNT_W), .AMT_W(AMT_W)) u_amount (
    .by_count (by_count),
    .count_reg(count_reg),
    .amt      (amt),
    .amt_zero (amt_zero),
    .amt_one  (amt_one)
  );

  srf_core #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_core (
    .op       (srf_op_e'(opcode)),
    .word_mode(word_mode),
    .operand  (operand),
    .carry_in (carry_in),
    .amt      (amt),
    .res      (core_res),
    .cy       (core_cy)
  );

  srf_flags #(.DATA_W(DATA_W)) u_flags (
    .word_mode(word_mode),
    .src      (src_masked),
    .res      (core_res),
    .sign_v   (sign_v),
    .zero_v   (zero_v),
    .par_v    (par_v),
    .sign_flip(sign_flip)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result <= '0;
      flg_q  <= '0;
    end else if (go) begin
      if (amt_zero) begin
        result <= src_masked;
      end else begin
        result   <= core_res;
        flg_q.cf <= core_cy;
        flg_q.sf <= sign_v;
        flg_q.zf <= zero_v;
        flg_q.pf <= par_v;
        if (amt_one) flg_q.of <= sign_flip;
      end
    end
  end

  assign cf = flg_q.cf;
  assign of = flg_q.of;
  assign sf = flg_q.sf;
  assign zf = flg_q.zf;
  assign pf = flg_q.pf;

  // R10: zero amount keeps flags and passes operand
  a_r10_zero_amount_holds: assert property (@(posedge clk) disable iff (!rst_n)
    go && amt_zero |=> $stable(cf) && $stable(of) && $stable(sf) && $stable(zf) && $stable(pf)
                       && result == $past(src_masked));

  // R8: overflow retained for amounts above one
  a_r8_of_kept: assert property (@(posedge clk) disable iff (!rst_n)
    go && !amt_zero && !amt_one |=> $stable(of));

  // R8: single position overflow reflects a sign change
  a_r8_of_single: assert property (@(posedge clk) disable iff (!rst_n)
    go && amt_one |=> of == ((word_mode ? result[DATA_W-1] : result[HALF_W-1])
                             ^ $past(word_mode ? operand[DATA_W-1] : operand[HALF_W-1])));

  // R9: zero and parity agree with the registered result
  a_r9_zero_parity: assert property (@(posedge clk) disable iff (!rst_n)
    go && !amt_zero |=> zf == (result == '0) && pf == ~(^result[7:0]));

  // R11: byte mode clears the upper half
  a_r11_byte_upper: assert property (@(posedge clk) disable iff (!rst_n)
    go && !word_mode |=> result[DATA_W-1:HALF_W] == '0);

  // R12: no request, no change
  a_r12_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !go |=> $stable(result) && $stable(flg_q));
endmodule

// File: tb/test_srf_unit.sv
module test_srf_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        go = 1'b0;
  logic [2:0]  opcode = '0;
  logic        word_mode = 1'b0;
  logic        by_count = 1'b0;
  logic [7:0]  count_reg = '0;
  logic [15:0] operand = '0;
  logic        carry_in = 1'b0;
  logic [15:0] result;
  logic        cf, of, sf, zf, pf;

  int compared = 0;
  int mismatched = 0;
  logic done = 1'b0;

  // expected flag state kept by the bench
  logic e_cf = 0, e_of = 0, e_sf = 0, e_zf = 0, e_pf = 0;
  logic [15:0] e_res = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  srf_unit i_srf_unit (
    .clk(clk), .rst_n(rst_n), .go(go), .opcode(opcode), .word_mode(word_mode),
    .by_count(by_count), .count_reg(count_reg), .operand(operand), .carry_in(carry_in),
    .result(result), .cf(cf), .of(of), .sf(sf), .zf(zf), .pf(pf)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // reference: returns {carry, result}; closed forms instead of stepping
  function automatic logic [16:0] model(input logic [2:0] o, input logic wm,
                                        input logic [15:0] din, input logic c, input int n);
    int          w, k, rw;
    logic [31:0] m, d, r, rr, rm, e;
    logic [63:0] v;
    logic signed [63:0] sv;
    logic        cy;
    w = wm ? 16 : 8;
    m = wm ? 32'hFFFF : 32'hFF;
    d = {16'b0, din} & m;
    r = 0; cy = 0;
    case (o)
      3'd0, 3'd1: begin v = 64'(d) << n; r = v[31:0] & m; cy = v[w]; end
      3'd2: begin v = 64'(d) << 32; v = v >> n; r = v[63:32] & m; cy = v[31]; end
      3'd3: begin
        e = d[w-1] ? (d | ~m) : d;
        sv = $signed({e, 32'b0}) >>> n;
        r = sv[63:32] & m; cy = sv[31];
      end
      3'd4: begin k = n % w; r = ((d << k) | (d >> (w - k))) & m; cy = r[0]; end
      3'd5: begin k = n % w; r = ((d >> k) | (d << (w - k))) & m; cy = r[w-1]; end
      default: begin
        rw = w + 1;
        rm = (32'd1 << rw) - 1;
        e  = d | (32'(c) << w);
        k  = n % rw;
        if (o == 3'd6) rr = ((e << k) | (e >> (rw - k))) & rm;
        else           rr = ((e >> k) | (e << (rw - k))) & rm;
        r = rr & m; cy = rr[w];
      end
    endcase
    return {cy, r[15:0]};
  endfunction

  task automatic run_op(input string req, input logic [2:0] o, input logic wm,
                        input logic bc, input logic [7:0] cnt, input logic [15:0] d,
                        input logic c);
    int          n, w;
    logic [16:0] mr;
    logic [15:0] dm;
    @(negedge clk);
    opcode = o; word_mode = wm; by_count = bc; count_reg = cnt; operand = d;
    carry_in = c; go = 1'b1;
    n  = bc ? int'(cnt[4:0]) : 1;
    w  = wm ? 16 : 8;
    dm = wm ? d : {8'h00, d[7:0]};
    if (n == 0) begin
      e_res = dm;
    end else begin
      mr = model(o, wm, d, c, n);
      e_res = mr[15:0];
      e_cf = mr[16];
      e_sf = e_res[w-1];
      e_zf = (e_res == 0);
      e_pf = ~(^e_res[7:0]);
      if (n == 1) e_of = e_res[w-1] ^ dm[w-1];
    end
    @(negedge clk);
    go = 1'b0;
    chk({req, " result"}, result, e_res);
    chk({req, " flags cf/of/sf/zf/pf"}, {11'b0, cf, of, sf, zf, pf},
        {11'b0, e_cf, e_of, e_sf, e_zf, e_pf});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'd4242);
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 reset result", result, 16'h0);
    chk("R1 reset flags", {11'b0, cf, of, sf, zf, pf}, 16'h0);
    rst_n = 1'b1;

    // R2 left shifts, both opcodes
    run_op("R2 shl FFh", 3'd0, 0, 0, 8'd0, 16'h00FF, 0);
    run_op("R2 sal FFh", 3'd1, 0, 0, 8'd0, 16'h00FF, 0);
    run_op("R2 shl 0Bh by 2", 3'd0, 0, 1, 8'd2, 16'h000B, 0);
    // R3 right shifts
    run_op("R3 shr FFh", 3'd2, 0, 0, 8'd0, 16'h00FF, 0);
    run_op("R3 sar FFh", 3'd3, 0, 0, 8'd0, 16'h00FF, 0);
    run_op("R3 shr 0Bh by 2", 3'd2, 0, 1, 8'd2, 16'h000B, 0);
    // R4 rotates, byte and word wrap
    run_op("R4 rol 0Bh", 3'd4, 0, 0, 8'd0, 16'h000B, 0);
    run_op("R4 ror 0Bh", 3'd5, 0, 0, 8'd0, 16'h000B, 0);
    run_op("R4 rol word 8000h", 3'd4, 1, 0, 8'd0, 16'h8000, 0);
    // R5 through-carry ring, full wraps
    run_op("R5 rcl byte by 9", 3'd6, 0, 1, 8'd9, 16'h0080, 1);
    run_op("R5 rcr word by 17", 3'd7, 1, 1, 8'd17, 16'h0001, 0);
    run_op("R5 rcl byte carry in", 3'd6, 0, 0, 8'd0, 16'h0000, 1);
    // R7 carry out past the width
    run_op("R7 shl byte by 9", 3'd0, 0, 1, 8'd9, 16'h00FF, 0);
    // R8 set OF, then amount 3 keeps it
    run_op("R8 of set", 3'd0, 0, 0, 8'd0, 16'h0040, 0);
    run_op("R8 of kept", 3'd2, 0, 1, 8'd3, 16'h0001, 0);
    // R6 count masking: 21h acts as 1
    run_op("R6 mask 21h", 3'd0, 1, 1, 8'h21, 16'h4000, 0);
    // R10 zero amount via masked count 20h
    run_op("R10 zero amount", 3'd0, 0, 1, 8'h20, 16'hAB5C, 1);
    // R11 byte mode ignores upper operand bits
    run_op("R11 byte upper ignored", 3'd3, 0, 0, 8'd0, 16'hFF01, 0);
    // R9 zero and parity
    run_op("R9 zero result", 3'd2, 1, 1, 8'd16, 16'hFFFF, 0);

    // R12 hold while idle
    begin
      logic [15:0] held;
      held = result;
      operand = 16'h1234; opcode = 3'd4;
      repeat (3) @(negedge clk);
      chk("R12 idle hold", result, held);
    end

    // random mix, count biased toward 0, 1 and masked-zero values
    for (int i = 0; i < 3000; i++) begin
      logic [7:0] cnt;
      int sel;
      sel = $urandom_range(0, 5);
      case (sel)
        0: cnt = 8'h00;
        1: cnt = 8'h01;
        2: cnt = {$urandom_range(0, 7), 5'b0};
        default: cnt = 8'($urandom);
      endcase
      run_op("R7 R8 R9 random", 3'($urandom), 1'($urandom), 1'($urandom), cnt,
             16'($urandom), 1'($urandom));
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule